// File: doc/BRIEF.md
# Cubic Residue Nonlinearity Corrector with Background Coefficient Tracking

This block sits at the digital output of a two-stage pipelined converter. The first-stage residue amplifier of that converter runs open-loop and compresses large signals. Each sample, the block takes the coarse first-stage code and the backend code. It reads a correction from a two-dimensional table. The table's rows are selected by a coefficient index and its columns by the backend residue code, and each entry cancels the third-order bending of the amplifier. The block then merges the corrected residue with the weighted coarse code and saturates the result into one 12-bit word.

The coefficient index is not fixed. A separate distance estimator compares two segment distances, h1 and h2, and raises a strobe when the comparison is valid. Each strobe nudges a fixed-point accumulator by a step proportional to h2 − h1. The index is the upper bits of that accumulator, so the table row follows the amplifier over process and temperature while conversion continues. The table is a computed ROM with a registered output. The coarse path carries one matching register.

Top module: `nlc_corrector`

## Requirements
- R1: After reset, out_valid is 0, out_code is 0 and coef_index is 4, because the accumulator restarts at 0x400.
- R2: A sample presented with in_valid high at clock edge k appears with out_valid high after edge k+2. When no sample was presented two edges earlier, out_valid is 0.
- R3: The output is out_code = clip(coarse·512 + backend − 256 + corr, 0, 4095), where coarse is 3 bits and backend is 10 bits unsigned.
- R4: The correction is corr = floor(idx · (backend − 512)³ / 2^24), where idx is the coefficient index in effect when the sample was presented. When idx is 0, corr is 0.
- R5: Each cycle with est_valid high adds (h2 − h1)·4 to the 12-bit accumulator, with h1 and h2 as 8-bit unsigned values. coef_index equals accumulator bits [11:8].
- R6: While est_valid is low, the accumulator and coef_index keep their value, whatever h1 and h2 are.
- R7: The accumulator saturates at 4095 and at 0 instead of wrapping.
- R8: If a sample and a coefficient update occur in the same cycle, that sample uses the index from before the update. Samples presented from the next cycle on use the new index.
- R9: A sum below 0 gives out_code 0, and a sum above 4095 gives out_code 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is present on the code inputs |
| coarse_code | input | 3 | First-stage code |
| backend_code | input | 10 | Backend residue code |
| est_valid | input | 1 | Distance estimate strobe |
| dist_h1 | input | 8 | First measured segment distance |
| dist_h2 | input | 8 | Second measured segment distance |
| out_valid | output | 1 | out_code holds a corrected sample |
| out_code | output | 12 | Corrected, saturated output word |
| coef_index | output | 4 | Current table row (accumulator upper bits) |

## Verification
Two functions can fall in the same cycle: a table read for a new sample and an accumulator update from the estimator. The bench provokes this by raising in_valid and est_valid together while the index is 0. It uses a backend code of 1023, because there the correction for index 1 differs from zero. The first output must show the old index, with no correction. A second sample presented one cycle later must carry the correction for index 1.

// File: rtl/nlc_pkg.sv
package nlc_pkg;
    localparam int COARSE_W_DEF = 3;
    localparam int BACK_W_DEF   = 10;
    localparam int DIST_W_DEF   = 8;
    localparam int ACC_W_DEF    = 12;
    localparam int IDX_W_DEF    = 4;

    typedef enum logic {
        UPD_MAGNITUDE = 1'b0,
        UPD_SIGN      = 1'b1
    } upd_mode_e;
endpackage

// File: rtl/nlc_coef_lms.sv
module nlc_coef_lms
    import nlc_pkg::*;
#(
    parameter int        DIST_W   = DIST_W_DEF,
    parameter int        ACC_W    = ACC_W_DEF,
    parameter int        IDX_W    = IDX_W_DEF,
    parameter int        STEP_SHL = 2,
    parameter int        ACC_INIT = 1024,
    parameter upd_mode_e MODE     = UPD_MAGNITUDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              est_valid,
    input  logic [DIST_W-1:0] dist_h1,
    input  logic [DIST_W-1:0] dist_h2,
    output logic [IDX_W-1:0]  coef_index
);
    localparam int SUM_W = ACC_W + 2;
    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } lms_state_t;

    lms_state_t state_d, state_q;
    logic signed [DIST_W:0]  diff;
    logic signed [SUM_W-1:0] delta;
    logic signed [SUM_W-1:0] sum;

    assign diff = $signed({1'b0, dist_h2}) - $signed({1'b0, dist_h1});

    generate
        if (MODE == UPD_SIGN) begin : g_sign
            always_comb begin
                if (diff > 0)      delta = SUM_W'(1 <<< STEP_SHL);
                else if (diff < 0) delta = -SUM_W'(1 <<< STEP_SHL);
                else               delta = '0;
            end
        end else begin : g_mag
            assign delta = SUM_W'(diff) <<< STEP_SHL;
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        sum     = $signed({2'b00, state_q.acc}) + delta;
        if (est_valid) begin
            if (sum < 0)                              state_d.acc = '0;
            else if (sum > $signed({2'b00, ACC_MAX})) state_d.acc = ACC_MAX;
            else                                      state_d.acc = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q.acc <= ACC_W'(ACC_INIT);
        else        state_q     <= state_d;
    end

    assign coef_index = state_q.acc[ACC_W-1 -: IDX_W];

    assert_hold_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !est_valid |=> $stable(state_q.acc));
    assert_rise_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (est_valid && dist_h2 > dist_h1) |=> state_q.acc >= $past(state_q.acc));
    assert_fall_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (est_valid && dist_h2 < dist_h1) |=> state_q.acc <= $past(state_q.acc));
endmodule

// File: rtl/nlc_corr_rom.sv
module nlc_corr_rom
    import nlc_pkg::*;
#(
    parameter int BACK_W     = BACK_W_DEF,
    parameter int IDX_W      = IDX_W_DEF,
    parameter int CUBE_SHIFT = 24,
    parameter int CORR_W     = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [IDX_W-1:0]         row_idx,
    input  logic [BACK_W-1:0]        col_code,
    output logic signed [CORR_W-1:0] corr
);
    localparam int R_W    = BACK_W + 1;
    localparam int CUBE_W = 3 * R_W;
    localparam int PROD_W = CUBE_W + IDX_W + 1;
    localparam logic signed [R_W-1:0] MID = R_W'(1 << (BACK_W - 1));

    typedef struct packed {
        logic signed [CORR_W-1:0] corr;
    } rom_state_t;

    rom_state_t state_d, state_q;
    logic signed [R_W-1:0]    r;
    logic signed [CUBE_W-1:0] cube;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        state_d = state_q;
        r       = $signed({1'b0, col_code}) - MID;
        cube    = CUBE_W'(r) * CUBE_W'(r) * CUBE_W'(r);
        prod    = PROD_W'(cube) * PROD_W'($signed({1'b0, row_idx}));
        if (rd_en) state_d.corr = CORR_W'(prod >>> CUBE_SHIFT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign corr = state_q.corr;

    assert_zero_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && row_idx == '0) |=> corr == '0);
    assert_centre_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && col_code == BACK_W'(1 << (BACK_W - 1))) |=> corr == '0);
endmodule

// File: rtl/nlc_recombine.sv
module nlc_recombine
    import nlc_pkg::*;
#(
    parameter int COARSE_W = COARSE_W_DEF,
    parameter int BACK_W   = BACK_W_DEF,
    parameter int CORR_W   = 14
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mid_valid,
    input  logic [COARSE_W-1:0]           mid_coarse,
    input  logic [BACK_W-1:0]             mid_back,
    input  logic signed [CORR_W-1:0]      mid_corr,
    output logic                          out_valid,
    output logic [COARSE_W+BACK_W-2:0]    out_code
);
    localparam int OUT_W  = COARSE_W + BACK_W - 1;
    localparam int SUM_W  = OUT_W + 3;
    localparam int OFFSET = 1 << (BACK_W - 2);
    localparam logic [OUT_W-1:0] OUT_MAX = {OUT_W{1'b1}};

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] code;
    } out_state_t;

    out_state_t state_d, state_q;
    logic signed [SUM_W-1:0] raw;

    always_comb begin
        state_d       = state_q;
        raw           = $signed(SUM_W'(mid_coarse) << (BACK_W - 1))
                      + $signed(SUM_W'(mid_back))
                      - $signed(SUM_W'(OFFSET))
                      + SUM_W'(mid_corr);
        state_d.valid = mid_valid;
        if (mid_valid) begin
            if (raw < 0)                                      state_d.code = '0;
            else if (raw > $signed({3'b000, OUT_MAX}))        state_d.code = OUT_MAX;
            else                                              state_d.code = raw[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.valid;
    assign out_code  = state_q.code;

    assert_clip_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_valid && raw < 0) |=> out_code == '0);
    assert_clip_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_valid && raw > $signed({3'b000, OUT_MAX})) |=> out_code == OUT_MAX);
endmodule

// File: rtl/nlc_corrector.sv
module nlc_corrector
    import nlc_pkg::*;
#(
    parameter int        COARSE_W   = COARSE_W_DEF,
    parameter int        BACK_W     = BACK_W_DEF,
    parameter int        DIST_W     = DIST_W_DEF,
    parameter int        ACC_W      = ACC_W_DEF,
    parameter int        IDX_W      = IDX_W_DEF,
    parameter int        STEP_SHL   = 2,
    parameter int        ACC_INIT   = 1024,
    parameter int        CUBE_SHIFT = 24,
    parameter upd_mode_e MODE       = UPD_MAGNITUDE
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [COARSE_W-1:0]        coarse_code,
    input  logic [BACK_W-1:0]          backend_code,
    input  logic                       est_valid,
    input  logic [DIST_W-1:0]          dist_h1,
    input  logic [DIST_W-1:0]          dist_h2,
    output logic                       out_valid,
    output logic [COARSE_W+BACK_W-2:0] out_code,
    output logic [IDX_W-1:0]           coef_index
);
    localparam int CORR_W = 3 * (BACK_W + 1) + IDX_W + 1 - CUBE_SHIFT;

    typedef struct packed {
        logic                valid;
        logic [COARSE_W-1:0] coarse;
        logic [BACK_W-1:0]   back;
    } align_t;

    align_t align_d, align_q;
    logic signed [CORR_W-1:0] corr;

    nlc_coef_lms #(
        .DIST_W(DIST_W), .ACC_W(ACC_W), .IDX_W(IDX_W),
        .STEP_SHL(STEP_SHL), .ACC_INIT(ACC_INIT), .MODE(MODE)
    ) u_lms (
        .clk(clk), .rst_n(rst_n), .est_valid(est_valid),
        .dist_h1(dist_h1), .dist_h2(dist_h2), .coef_index(coef_index)
    );

    nlc_corr_rom #(
        .BACK_W(BACK_W), .IDX_W(IDX_W), .CUBE_SHIFT(CUBE_SHIFT), .CORR_W(CORR_W)
    ) u_rom (
        .clk(clk), .rst_n(rst_n), .rd_en(in_valid),
        .row_idx(coef_index), .col_code(backend_code), .corr(corr)
    );

    always_comb begin
        align_d       = align_q;
        align_d.valid = in_valid;
        if (in_valid) begin
            align_d.coarse = coarse_code;
            align_d.back   = backend_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) align_q <= '0;
        else        align_q <= align_d;
    end

    nlc_recombine #(
        .COARSE_W(COARSE_W), .BACK_W(BACK_W), .CORR_W(CORR_W)
    ) u_comb (
        .clk(clk), .rst_n(rst_n), .mid_valid(align_q.valid),
        .mid_coarse(align_q.coarse), .mid_back(align_q.back), .mid_corr(corr),
        .out_valid(out_valid), .out_code(out_code)
    );

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));
endmodule

// File: tb/nlc_corrector_test.sv
module nlc_corrector_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  coarse_code = '0;
    logic [9:0]  backend_code = '0;
    logic        est_valid = 1'b0;
    logic [7:0]  dist_h1 = '0;
    logic [7:0]  dist_h2 = '0;
    logic        out_valid;
    logic [11:0] out_code;
    logic [3:0]  coef_index;

    int checks = 0;
    int errors = 0;
    int acc_m  = 1024;

    always #5 clk = ~clk;

    nlc_corrector uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .coarse_code(coarse_code),
        .backend_code(backend_code), .est_valid(est_valid), .dist_h1(dist_h1),
        .dist_h2(dist_h2), .out_valid(out_valid), .out_code(out_code),
        .coef_index(coef_index)
    );

    localparam logic [12:0] VEC [10] = '{
        {3'd3, 10'd512}, {3'd0, 10'd0},   {3'd7, 10'd1023}, {3'd1, 10'd100},
        {3'd5, 10'd900}, {3'd2, 10'd300}, {3'd4, 10'd700},  {3'd6, 10'd1000},
        {3'd0, 10'd280}, {3'd7, 10'd800}
    };

    function automatic int model_out(int c, int b, int idx);
        longint r, prod, corr, raw;
        r    = longint'(b) - 512;
        prod = longint'(idx) * r * r * r;
        corr = prod >>> 24;
        raw  = longint'(c) * 512 + longint'(b) - 256 + corr;
        if (raw < 0) return 0;
        if (raw > 4095) return 4095;
        return int'(raw);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic sample(input int c, input int b, input string tag);
        int idx;
        idx = acc_m >> 8;
        @(negedge clk);
        in_valid = 1'b1; coarse_code = 3'(c); backend_code = 10'(b);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R2 not yet valid"}, int'(out_valid), 0);
        @(negedge clk);
        check({tag, " R2 valid"}, int'(out_valid), 1);
        check({tag, " R3"}, int'(out_code), model_out(c, b, idx));
    endtask

    task automatic update(input int h1, input int h2, input string tag);
        @(negedge clk);
        est_valid = 1'b1; dist_h1 = 8'(h1); dist_h2 = 8'(h2);
        acc_m = acc_m + (h2 - h1) * 4;
        if (acc_m < 0) acc_m = 0;
        if (acc_m > 4095) acc_m = 4095;
        @(negedge clk);
        est_valid = 1'b0;
        check(tag, int'(coef_index), acc_m >> 8);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_code", int'(out_code), 0);
        check("R1 coef_index", int'(coef_index), 4);
        rst_n = 1'b1;

        foreach (VEC[i]) sample(int'(VEC[i][12:10]), int'(VEC[i][9:0]), "vector R4");
        sample(0, 0, "R9 clip low");
        sample(7, 1023, "R9 clip high");

        update(100, 164, "R5 step up");
        update(90, 30, "R5 step down");
        update(10, 74, "R5 step up again");
        @(negedge clk);
        est_valid = 1'b0; dist_h1 = 8'd0; dist_h2 = 8'd255;
        repeat (3) @(negedge clk);
        check("R6 hold without strobe", int'(coef_index), acc_m >> 8);
        sample(2, 1000, "R6 row after hold");

        for (int k = 0; k < 5; k++) update(0, 255, "R7 saturate high");
        check("R7 top", int'(coef_index), 15);
        sample(1, 0, "R7 row 15");
        for (int k = 0; k < 6; k++) update(255, 0, "R7 saturate low");
        check("R7 bottom", int'(coef_index), 0);
        sample(2, 1023, "R4 row zero");

        @(negedge clk);
        in_valid = 1'b1; coarse_code = 3'd2; backend_code = 10'd1023;
        est_valid = 1'b1; dist_h1 = 8'd0; dist_h2 = 8'd64;
        @(negedge clk);
        est_valid = 1'b0;
        coarse_code = 3'd2; backend_code = 10'd1023;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 old row used", int'(out_code), model_out(2, 1023, 0));
        @(negedge clk);
        check("R8 new row used", int'(out_code), model_out(2, 1023, 1));
        check("R8 index", int'(coef_index), 1);

        summary();
        $finish;
    end
endmodule